// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches eight external interrupt pins and one non-maskable interrupt pin. For each of the eight pins it applies a sense mode that software selects. The modes are low level, falling edge, rising edge and both edges. The block keeps one pending request per channel. Each pending request leaves the block as an active-high level on its own line to a downstream interrupt controller, whatever sense the pin uses. Priority, masking and vectoring belong to that downstream controller and are not part of this block.

Every pin goes through a two-flop synchronizer before detection. A small 16-bit register bus reaches three registers: a control word, a sense-select word and a request word. A pending edge request stays set until software writes a zero to its bit. Writing a one leaves the bit as it is, so one channel is cleared by writing all ones except that channel's bit. The control word holds the non-maskable pin's edge choice and request flag, and lets software read the synchronized level of that pin.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, irq_o and nmi_irq_o are 0. The sense and request words read 0. The control word reads 0x8000 when the non-maskable pin is high.
- R2: Word offsets: control at byte address 0, sense at 2, request at 4. Address 6 reads 0. Request bits [15:8] read 0. In the control word only bits 15, 8 and 1 are ever nonzero. A sense write reads back unchanged.
- R3: Channel n takes its mode from sense bits [2n+1:2n]. Code 0 is low level, 1 is falling edge, 2 is rising edge and 3 is either edge. An edge of the wrong direction sets nothing.
- R4: In an edge mode, a detected edge sets pending bit n in request bit n, and irq_o[n] shows it. The bit stays set after the pin returns to its idle level.
- R5: A request write with bit n at 0 clears an edge-mode pending bit n. A write with bit n at 1 leaves it unchanged.
- R6: In level mode, pending bit n follows the inverted synchronized pin and does not latch. A clear write while the pin is low has no lasting effect, and the bit drops once the pin is high.
- R7: If an edge is detected on channel n in the same cycle as a clear write to that bit, the bit stays set.
- R8: A pin change driven before clock edge k reaches irq_o after edge k+2, and not earlier.
- R9: The non-maskable pin sets control bit 1 and nmi_irq_o on the edge that control bit 8 selects: 0 for falling, 1 for rising. Writing 0 to bit 1 clears it, and writing 1 there leaves it set.
- R10: Control bit 15 reads the synchronized level of the non-maskable pin, where 1 means high.
- R11: Activity on one channel does not change the pending bit of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | 8 | External interrupt pins, asynchronous |
| nmi_pin_i | input | 1 | Non-maskable interrupt pin, asynchronous |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 3 | Byte address of the register word |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| irq_o | output | 8 | Active-high level request per channel |
| nmi_irq_o | output | 1 | Active-high non-maskable request |

## Verification
The bench sweeps every channel through all four sense codes. For each it drives a falling pin, then a rising pin, then an all-ones write, then a single-bit clear. The expected pending vector tells apart latched from following behaviour and right from wrong edge direction, and shows whether neighbouring channels stay quiet. Separate directed patterns place a pin change at a known clock edge to pin down the two-stage latency. One of them lines a clear write up with the edge-detect cycle to show that the edge wins. The non-maskable pin is run under both edge choices, with the pin level read back through the control word.

// File: rtl/eis_pkg.sv
package eis_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'd0,
    SENSE_FALL = 2'd1,
    SENSE_RISE = 2'd2,
    SENSE_BOTH = 2'd3
  } sense_e;

  localparam int DATA_W       = 16;
  localparam int ADDR_W       = 3;
  localparam int WORD_CTRL    = 0;
  localparam int WORD_SENSE   = 1;
  localparam int WORD_REQ     = 2;
  localparam int NMI_LVL_BIT  = 15;
  localparam int NMI_EDGE_BIT = 8;
  localparam int NMI_FLAG_BIT = 1;

  // edge event under a given sense mode, from previous and current sample
  function automatic logic edge_hit(input sense_e mode, input logic prev, input logic now);
    logic rise;
    logic fall;
    rise = ~prev & now;
    fall = prev & ~now;
    case (mode)
      SENSE_FALL: edge_hit = fall;
      SENSE_RISE: edge_hit = rise;
      SENSE_BOTH: edge_hit = rise | fall;
      default:    edge_hit = 1'b0;
    endcase
  endfunction

  // next pending state of one channel
  function automatic logic pend_next(input sense_e mode, input logic now,
                                     input logic ev, input logic cur, input logic clr);
    if (mode == SENSE_LOW) pend_next = ~now;
    else                   pend_next = ev | (cur & ~clr);
  endfunction

endpackage

// File: rtl/eis_sync.sv
module eis_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2,
  parameter logic IDLE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= {WIDTH{IDLE}};
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/eis_channel.sv
module eis_channel
  import eis_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  sense_e mode_i,
  input  logic   now_i,
  input  logic   clr_i,
  output logic   event_o,
  output logic   pend_o
);
  logic prev_q;
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      prev_q <= now_i;
      pend_q <= pend_next(mode_i, now_i, event_o, pend_q, clr_i);
    end
  end

  assign event_o = edge_hit(mode_i, prev_q, now_i);
  assign pend_o  = pend_q;
endmodule

// File: rtl/eis_regs.sv
module eis_regs
  import eis_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_CH-1:0]   pend_i,
  input  logic                nmi_pend_i,
  input  logic                nmi_level_i,
  output logic [2*NUM_CH-1:0] sense_o,
  output logic                nmi_rise_o,
  output logic [NUM_CH-1:0]   clr_o,
  output logic                nmi_clr_o
);
  localparam int SENSE_W = 2 * NUM_CH;

  logic [1:0]         word_sel;
  logic               wr_en;
  logic [SENSE_W-1:0] sense_q;
  logic               nmi_rise_q;
  logic               unused_bits;

  assign word_sel = bus_addr[ADDR_W-1:1];
  assign wr_en    = bus_sel & bus_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q    <= '0;
      nmi_rise_q <= 1'b0;
    end else if (wr_en) begin
      if (word_sel == 2'(WORD_SENSE)) sense_q    <= bus_wdata[SENSE_W-1:0];
      if (word_sel == 2'(WORD_CTRL))  nmi_rise_q <= bus_wdata[NMI_EDGE_BIT];
    end
  end

  // clear strobes: a zero in the written bit clears that request
  assign clr_o     = (wr_en && word_sel == 2'(WORD_REQ)) ? ~bus_wdata[NUM_CH-1:0] : '0;
  assign nmi_clr_o = wr_en && word_sel == 2'(WORD_CTRL) && !bus_wdata[NMI_FLAG_BIT];

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (word_sel)
        2'(WORD_CTRL): begin
          bus_rdata[NMI_LVL_BIT]  = nmi_level_i;
          bus_rdata[NMI_EDGE_BIT] = nmi_rise_q;
          bus_rdata[NMI_FLAG_BIT] = nmi_pend_i;
        end
        2'(WORD_SENSE): bus_rdata[SENSE_W-1:0] = sense_q;
        2'(WORD_REQ):   bus_rdata[NUM_CH-1:0]  = pend_i;
        default:        bus_rdata = '0;
      endcase
    end
  end

  assign sense_o     = sense_q;
  assign nmi_rise_o  = nmi_rise_q;
  assign unused_bits = ^{bus_addr[0], bus_wdata};
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import eis_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] pin_i,
  input  logic              nmi_pin_i,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic [NUM_CH-1:0] irq_o,
  output logic              nmi_irq_o
);
  localparam int PIN_W = NUM_CH + 1;

  logic [PIN_W-1:0]    sync_w;
  logic [NUM_CH-1:0]   pin_now;
  logic                nmi_now;
  logic [2*NUM_CH-1:0] sense_q;
  logic                nmi_rise;
  logic [NUM_CH-1:0]   ch_clr;
  logic [NUM_CH-1:0]   ch_event;
  logic [NUM_CH-1:0]   ch_pend;
  logic                nmi_clr;
  logic                nmi_event;
  logic                nmi_pend;
  sense_e              nmi_mode;

  eis_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({nmi_pin_i, pin_i}),
    .q_o   (sync_w)
  );

  assign pin_now = sync_w[NUM_CH-1:0];
  assign nmi_now = sync_w[NUM_CH];

  eis_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .pend_i      (ch_pend),
    .nmi_pend_i  (nmi_pend),
    .nmi_level_i (nmi_now),
    .sense_o     (sense_q),
    .nmi_rise_o  (nmi_rise),
    .clr_o       (ch_clr),
    .nmi_clr_o   (nmi_clr)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    eis_channel u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode_i  (sense_e'(sense_q[2*i +: 2])),
      .now_i   (pin_now[i]),
      .clr_i   (ch_clr[i]),
      .event_o (ch_event[i]),
      .pend_o  (ch_pend[i])
    );
  end

  // the non-maskable channel reuses the edge logic with a one-bit choice
  assign nmi_mode = nmi_rise ? SENSE_RISE : SENSE_FALL;

  eis_channel u_nmi (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (nmi_mode),
    .now_i   (nmi_now),
    .clr_i   (nmi_clr),
    .event_o (nmi_event),
    .pend_o  (nmi_pend)
  );

  assign irq_o     = ch_pend;
  assign nmi_irq_o = nmi_pend;
endmodule

// File: rtl/ext_irq_sense_chk.sv
module ext_irq_sense_chk #(
  parameter int NUM_CH = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [2*NUM_CH-1:0] sense,
  input logic [NUM_CH-1:0]   sync_now,
  input logic [NUM_CH-1:0]   ev,
  input logic [NUM_CH-1:0]   clr,
  input logic [NUM_CH-1:0]   irq,
  input logic                nmi_ev,
  input logic                nmi_clr,
  input logic                nmi_irq,
  input logic                bus_sel,
  input logic                bus_wr,
  input logic [2:0]          bus_addr,
  input logic [15:0]         bus_rdata
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_prop
    // R4: an edge-mode pending bit holds without a clear
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (sense[2*i +: 2] != 2'd0 && irq[i] && !clr[i]) |=> irq[i]);
    // R5: clear with no edge drops the bit
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (sense[2*i +: 2] != 2'd0 && clr[i] && !ev[i]) |=> !irq[i]);
    // R6: level mode follows the inverted pin
    a_r6_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (sense[2*i +: 2] == 2'd0) |=> (irq[i] == !$past(sync_now[i])));
    // R7: edge beats a simultaneous clear
    a_r7_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (sense[2*i +: 2] != 2'd0 && ev[i]) |=> irq[i]);
    // R3: no rise of an edge-mode bit without an event
    a_r3_rise_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
      (sense[2*i +: 2] != 2'd0 && !ev[i]) |=> !$rose(irq[i]));
  end

  // R9: the non-maskable flag holds until a clear
  a_r9_nmi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_irq && !nmi_clr) |=> nmi_irq);
  a_r9_nmi_set: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_ev |=> nmi_irq);
  // R2: request word upper bits read zero
  a_r2_req_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr[2:1] == 2'd2) |-> (bus_rdata[15:8] == 8'h00));
endmodule

bind ext_irq_sense ext_irq_sense_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sense     (sense_q),
  .sync_now  (pin_now),
  .ev        (ch_event),
  .clr       (ch_clr),
  .irq       (irq_o),
  .nmi_ev    (nmi_event),
  .nmi_clr   (nmi_clr),
  .nmi_irq   (nmi_irq_o),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata)
);

// File: tb/ext_irq_sense_bench.sv
`timescale 1ns/1ps
module ext_irq_sense_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pin_i = 8'hFF;
  logic        nmi_pin_i = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic [7:0]  irq_o;
  logic        nmi_irq_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ext_irq_sense u_ext_irq_sense (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .nmi_pin_i(nmi_pin_i),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .nmi_irq_o(nmi_irq_o)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] q);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 q = bus_rdata;
    bus_sel = 1'b0;
  endtask

  initial begin : main
    logic [15:0] q;
    logic [7:0]  bitv;
    logic [7:0]  exp_v;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R1 reset state
    check("R1 irq", {8'h0, irq_o}, 16'h0);
    check("R1 nmi", {15'h0, nmi_irq_o}, 16'h0);
    rd(3'd0, q); check("R1 R10 ctrl", q, 16'h8000);
    rd(3'd2, q); check("R1 sense", q, 16'h0);
    rd(3'd4, q); check("R1 req", q, 16'h0);
    // R2 readback and unmapped word
    wr(3'd2, 16'hA5C3); rd(3'd2, q); check("R2 sense readback", q, 16'hA5C3);
    rd(3'd6, q); check("R2 unmapped", q, 16'h0);

    // R3 R4 R5 R6 R11 sweep: every channel, every sense code
    for (int m = 0; m < 4; m++) begin
      for (int n = 0; n < 8; n++) begin
        bitv = 8'(1 << n);
        wr(3'd2, {8{2'(m)}});
        wr(3'd4, 16'h0000);
        tick(4);
        check($sformatf("R11 idle ch%0d m%0d", n, m), {8'h0, irq_o}, 16'h0);
        @(negedge clk); pin_i[n] = 1'b0;
        tick(4);
        exp_v = (m != 2) ? bitv : 8'h0;
        check($sformatf("R3 fall ch%0d m%0d", n, m), {8'h0, irq_o}, {8'h0, exp_v});
        rd(3'd4, q); check($sformatf("R4 req read ch%0d m%0d", n, m), q, {8'h0, exp_v});
        if (m == 0) begin
          wr(3'd4, {8'hFF, ~bitv});
          tick(2);
          check($sformatf("R6 clear while low ch%0d", n), {8'h0, irq_o}, {8'h0, bitv});
        end
        @(negedge clk); pin_i[n] = 1'b1;
        tick(4);
        exp_v = (m == 0) ? 8'h0 : bitv;
        check($sformatf("R4 R3 rise ch%0d m%0d", n, m), {8'h0, irq_o}, {8'h0, exp_v});
        wr(3'd4, 16'hFFFF); tick(1);
        check($sformatf("R5 ones keep ch%0d m%0d", n, m), {8'h0, irq_o}, {8'h0, exp_v});
        wr(3'd4, {8'hFF, ~bitv}); tick(1);
        check($sformatf("R5 clear ch%0d m%0d", n, m), {8'h0, irq_o}, 16'h0);
      end
    end

    // R8 latency on channel 2 in falling mode
    wr(3'd2, 16'h5555); wr(3'd4, 16'h0); tick(4);
    @(negedge clk); pin_i[2] = 1'b0;
    tick(2); check("R8 not yet", {8'h0, irq_o}, 16'h0);
    tick(1); check("R8 arrives", {8'h0, irq_o}, 16'h0004);
    @(negedge clk); pin_i[2] = 1'b1; wr(3'd4, 16'h0); tick(4);

    // R7 edge and clear in the same cycle, channel 5 rising
    wr(3'd2, 16'hAAAA); wr(3'd4, 16'h0); tick(4);
    @(negedge clk); pin_i[5] = 1'b0; tick(4); wr(3'd4, 16'h0); tick(1);
    check("R7 before", {8'h0, irq_o}, 16'h0);
    @(negedge clk); pin_i[5] = 1'b1;
    @(negedge clk);
    wr(3'd4, 16'h00DF);
    check("R7 edge wins", {8'h0, irq_o}, 16'h0020);
    wr(3'd4, 16'h00DF); tick(1);
    check("R7 later clear", {8'h0, irq_o}, 16'h0);

    // R9 R10 non-maskable pin
    @(negedge clk); nmi_pin_i = 1'b0; tick(4);
    check("R9 falling", {15'h0, nmi_irq_o}, 16'h1);
    rd(3'd0, q); check("R10 ctrl low", q, 16'h0002);
    wr(3'd0, 16'h0002); tick(1);
    check("R9 one keeps", {15'h0, nmi_irq_o}, 16'h1);
    wr(3'd0, 16'h0000); tick(1);
    check("R9 zero clears", {15'h0, nmi_irq_o}, 16'h0);
    wr(3'd0, 16'h0100); tick(2);
    rd(3'd0, q); check("R9 edge select", q, 16'h0100);
    @(negedge clk); nmi_pin_i = 1'b1; tick(4);
    check("R9 rising", {15'h0, nmi_irq_o}, 16'h1);
    rd(3'd0, q); check("R10 ctrl high", q, 16'h8102);
    wr(3'd0, 16'h0100); tick(1);
    rd(3'd0, q); check("R9 cleared", q, 16'h8100);
    check("R11 pins quiet", {8'h0, irq_o}, 16'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule